// File: doc/BRIEF.md
# Floating-Point Compare and Exception Status Unit

This unit owns a 64-bit floating-point status register and updates it from two kinds of operation. A compare operation arrives with its result already classified as equal, less, greater or unordered. The unit writes that result as a 2-bit condition code into one of four selectable condition fields. An arithmetic-completion operation arrives with the five IEEE flags raised by the datapath. The unit places them in the current-exception field. Then, depending on the trap-enable field, it either folds them into the accrued field or signals a trap.

Operations enter through a valid/ready port. The unit accepts an operation on any cycle where both are high. Ready drops while a whole-register load is presented, and it stays low for as long as the trap-type field is nonzero: after a trap, the handler must reload the register before further operations are taken. Offers made while ready is low are ignored, and the source must hold them. Loads are always accepted. The register value and a one-cycle trap pulse appear one clock after acceptance.

Top module: `fpcx_top`

## Requirements
- R1: A synchronous reset clears all 64 status bits, trap_o and trap_kind_o.
- R2: An accepted compare writes the relation code into the selected field, both bits at once: 00 equal, 01 less, 10 greater, 11 unordered. An ordered result changes no other bit.
- R3: Field select 0, 1, 2 and 3 place the code at bits 11:10, 33:32, 35:34 and 37:36 respectively.
- R4: An unordered compare traps when the invalid trap-enable bit 27 is set or cmp_signal_i is high. It then sets current-invalid bit 4, sets the trap-type field 16:14 to 1 and pulses trap_o.
- R5: An unordered compare that does not trap sets accrued-invalid bit 9 and changes no exception or trap-type bit besides it.
- R6: An accepted arithmetic operation replaces bits 4:0 with exc_flags_i, ordered invalid(4), overflow(3), underflow(2), divide-by-zero(1), inexact(0).
- R7: An arithmetic operation traps when exc_flags_i AND bits 27:23 is nonzero. It then sets field 16:14 to 1 and leaves the accrued field 9:5 unchanged.
- R8: An arithmetic operation that does not trap ORs exc_flags_i into accrued bits 9:5.
- R9: trap_o is high for exactly the one cycle after a trapping operation, and trap_kind_o shows 1 in that cycle and 0 otherwise.
- R10: op_ready_o is low while ld_en_i is high or field 16:14 is nonzero. A load replaces the whole register. An offered operation that is not accepted leaves the register and trap_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Operation can be accepted |
| op_arith_i | input | 1 | 1 = arithmetic flags, 0 = compare |
| cmp_rel_i | input | 2 | Relation code of the compare |
| cmp_sel_i | input | 2 | Condition field select |
| cmp_signal_i | input | 1 | Signaling compare variant |
| exc_flags_i | input | 5 | IEEE flags of the arithmetic operation |
| ld_en_i | input | 1 | Load whole status register |
| ld_data_i | input | 64 | Value to load |
| fsr_o | output | 64 | Status register |
| trap_o | output | 1 | Trap pulse |
| trap_kind_o | output | 3 | Trap type during the pulse |

## Verification
Compares are tried in every field with every relation, and the unordered case is crossed with the trap-enable bit and the signaling flag. This separates the trapping, accruing and plain paths and shows whether a write spills into a neighbouring field. Arithmetic flags are tried with enables that overlap them and with enables that miss them, which separates the accrue path from the trap path. Random loads, including loads that leave a nonzero trap-type field, show whether operations offered while not ready are kept out.

// File: rtl/fpcx_pkg.sv
package fpcx_pkg;
  localparam int FSR_W    = 64;
  localparam int N_CC     = 4;
  localparam int CC_W     = 2;
  localparam int CC_BASE  = 10;
  localparam int EXC_W    = 5;
  localparam int CEXC_LO  = 0;
  localparam int AEXC_LO  = CEXC_LO + EXC_W;
  localparam int TEM_LO   = 23;
  localparam int NV_IDX   = 4;
  localparam int FTT_LO   = 14;
  localparam int FTT_W    = 3;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;
  localparam logic [CC_W-1:0]  REL_UNORD = 2'b11;

  typedef enum logic {OP_CMP = 1'b0, OP_ARITH = 1'b1} op_kind_e;

  function automatic int cc_pos(input int sel);
    case (sel)
      0: cc_pos = CC_BASE;
      1: cc_pos = CC_BASE + 22;
      2: cc_pos = CC_BASE + 24;
      default: cc_pos = CC_BASE + 26;
    endcase
  endfunction
endpackage

// File: rtl/fpcx_cmp.sv
module fpcx_cmp
  import fpcx_pkg::*;
(
  input  logic [FSR_W-1:0] cur_i,
  input  logic [CC_W-1:0]  rel_i,
  input  logic [1:0]       sel_i,
  input  logic             signal_i,
  output logic [FSR_W-1:0] nxt_o,
  output logic             trap_o
);
  logic [N_CC-1:0] hit;
  logic [FSR_W-1:0] field_mask, field_val;

  genvar k;
  generate
    for (k = 0; k < N_CC; k++) begin : g_fld
      assign hit[k] = (sel_i == k[1:0]);
    end
  endgenerate

  always_comb begin
    field_mask = '0;
    field_val  = '0;
    for (int j = 0; j < N_CC; j++) begin
      if (hit[j]) begin
        field_mask[cc_pos(j) +: CC_W] = '1;
        field_val[cc_pos(j) +: CC_W]  = rel_i;
      end
    end
  end

  always_comb begin
    nxt_o  = (cur_i & ~field_mask) | field_val;
    trap_o = 1'b0;
    if (rel_i == REL_UNORD) begin
      if (cur_i[TEM_LO + NV_IDX] || signal_i) begin
        nxt_o[CEXC_LO + NV_IDX]     = 1'b1;
        nxt_o[FTT_LO +: FTT_W]      = FTT_IEEE;
        trap_o                      = 1'b1;
      end else begin
        nxt_o[AEXC_LO + NV_IDX]     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpcx_exc.sv
module fpcx_exc
  import fpcx_pkg::*;
(
  input  logic [FSR_W-1:0] cur_i,
  input  logic [EXC_W-1:0] flags_i,
  output logic [FSR_W-1:0] nxt_o,
  output logic             trap_o
);
  logic [EXC_W-1:0] unmasked;
  assign unmasked = flags_i & cur_i[TEM_LO +: EXC_W];

  always_comb begin
    nxt_o = cur_i;
    nxt_o[CEXC_LO +: EXC_W] = flags_i;
    trap_o = |unmasked;
    if (trap_o) nxt_o[FTT_LO +: FTT_W] = FTT_IEEE;
    else        nxt_o[AEXC_LO +: EXC_W] = cur_i[AEXC_LO +: EXC_W] | flags_i;
  end
endmodule

// File: rtl/fpcx_top.sv
module fpcx_top
  import fpcx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic              op_arith_i,
  input  logic [1:0]        cmp_rel_i,
  input  logic [1:0]        cmp_sel_i,
  input  logic              cmp_signal_i,
  input  logic [4:0]        exc_flags_i,
  input  logic              ld_en_i,
  input  logic [63:0]       ld_data_i,
  output logic [63:0]       fsr_o,
  output logic              trap_o,
  output logic [2:0]        trap_kind_o
);
  logic [FSR_W-1:0] fsr_q, cmp_nxt, exc_nxt;
  logic cmp_trap, exc_trap, trap_q, fire;
  op_kind_e kind;

  assign kind       = op_kind_e'(op_arith_i);
  assign op_ready_o = !ld_en_i && (fsr_q[FTT_LO +: FTT_W] == '0);
  assign fire       = op_valid_i && op_ready_o;

  fpcx_cmp u_cmp (.cur_i(fsr_q), .rel_i(cmp_rel_i), .sel_i(cmp_sel_i),
                  .signal_i(cmp_signal_i), .nxt_o(cmp_nxt), .trap_o(cmp_trap));
  fpcx_exc u_exc (.cur_i(fsr_q), .flags_i(exc_flags_i), .nxt_o(exc_nxt),
                  .trap_o(exc_trap));

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q  <= '0;
      trap_q <= 1'b0;
    end else if (ld_en_i) begin
      fsr_q  <= ld_data_i;
      trap_q <= 1'b0;
    end else if (fire) begin
      fsr_q  <= (kind == OP_ARITH) ? exc_nxt : cmp_nxt;
      trap_q <= (kind == OP_ARITH) ? exc_trap : cmp_trap;
    end else begin
      trap_q <= 1'b0;
    end
  end

  assign fsr_o       = fsr_q;
  assign trap_o      = trap_q;
  assign trap_kind_o = trap_q ? FTT_IEEE : '0;

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (fsr_q == '0 && !trap_q));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst) trap_q |=> !trap_q);
  a_r4_trap_type: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> fsr_q[FTT_LO +: FTT_W] == FTT_IEEE);
  a_r2_code_written: assert property (@(posedge clk) disable iff (rst)
    (fire && !op_arith_i && cmp_sel_i == 2'd0) |=> fsr_q[CC_BASE +: CC_W] == $past(cmp_rel_i));
  a_r8_accrue: assert property (@(posedge clk) disable iff (rst)
    (fire && op_arith_i && (exc_flags_i & fsr_q[TEM_LO +: EXC_W]) == '0)
    |=> fsr_q[AEXC_LO +: EXC_W] == ($past(fsr_q[AEXC_LO +: EXC_W]) | $past(exc_flags_i)));
  a_r7_accrued_held: assert property (@(posedge clk) disable iff (rst)
    (fire && op_arith_i) |=> (trap_q -> $stable(fsr_q[AEXC_LO +: EXC_W])));
  a_r10_blocked: assert property (@(posedge clk) disable iff (rst)
    (!ld_en_i && !fire) |=> ($stable(fsr_q) && !trap_q));
endmodule

// File: tb/sim_fpcx_top.sv
`timescale 1ns/1ps
module sim_fpcx_top;
  logic clk = 0, rst = 1;
  logic op_valid = 0, op_arith = 0, cmp_signal = 0, ld_en = 0;
  logic [1:0] cmp_rel = 0, cmp_sel = 0;
  logic [4:0] flags = 0;
  logic [63:0] ld_data = 0;
  logic op_ready, trap;
  logic [2:0] trap_kind;
  logic [63:0] fsr;
  int errors = 0, checks = 0;
  logic done = 0;
  logic [63:0] m_fsr = 0;
  logic m_trap = 0;

  always #2 clk = ~clk;

  fpcx_top u0 (.clk(clk), .rst(rst), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .op_arith_i(op_arith), .cmp_rel_i(cmp_rel), .cmp_sel_i(cmp_sel),
    .cmp_signal_i(cmp_signal), .exc_flags_i(flags), .ld_en_i(ld_en),
    .ld_data_i(ld_data), .fsr_o(fsr), .trap_o(trap), .trap_kind_o(trap_kind));

  function automatic int pos_of(input logic [1:0] s);
    case (s) 2'd0: return 10; 2'd1: return 32; 2'd2: return 34; default: return 36; endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, sample at next negedge
  task automatic step(input logic l, input logic [63:0] ld, input logic v, input logic a,
                      input logic [1:0] rel, input logic [1:0] sel, input logic sg,
                      input logic [4:0] fl);
    logic rdy, t;
    logic [63:0] n;
    string tag;
    ld_en = l; ld_data = ld; op_valid = v; op_arith = a;
    cmp_rel = rel; cmp_sel = sel; cmp_signal = sg; flags = fl;
    rdy = !l && (m_fsr[16:14] == 3'd0);
    #0.5;
    check("R10 ready", {63'd0, op_ready}, {63'd0, rdy});
    n = m_fsr; t = 0; tag = "R10 hold";
    if (l) begin n = ld; tag = "R10 load"; end
    else if (v && rdy && a) begin
      n[4:0] = fl;
      if ((fl & m_fsr[27:23]) != 0) begin n[16:14] = 3'd1; t = 1; tag = "R7 arith trap"; end
      else begin n[9:5] = m_fsr[9:5] | fl; tag = "R8 R6 arith accrue"; end
    end else if (v && rdy) begin
      n[pos_of(sel) +: 2] = rel;
      tag = "R2 R3 compare";
      if (rel == 2'b11) begin
        if (m_fsr[27] || sg) begin n[4] = 1; n[16:14] = 3'd1; t = 1; tag = "R4 unordered trap"; end
        else begin n[9] = 1; tag = "R5 unordered accrue"; end
      end
    end
    m_fsr = n; m_trap = t;
    @(negedge clk);
    check(tag, fsr, m_fsr);
    check("R9 trap", {61'd0, trap, trap_kind[1:0]}, {61'd0, m_trap, 1'b0, m_trap});
    check("R9 kind hi", {63'd0, trap_kind[2]}, 64'd0);
  endtask

  initial begin
    #300000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1 reset fsr", fsr, 64'd0);
    check("R1 reset trap", {61'd0, trap, trap_kind[1:0]}, 64'd0);
    // R2 R3: every relation in every field
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 3; r++)
        step(0, 0, 1, 0, r[1:0], s[1:0], 0, 0);
    // R5: unordered, no enables
    step(0, 0, 1, 0, 2'b11, 2'd2, 0, 0);
    // R4: signaling unordered traps, then blocked offer, then reload
    step(0, 0, 1, 0, 2'b11, 2'd1, 1, 0);
    step(0, 0, 1, 1, 0, 0, 0, 5'h1f);
    step(1, 64'h0000_0000_0800_0000, 0, 0, 0, 0, 0, 0);
    // R4: invalid enable bit 27 set
    step(0, 0, 1, 0, 2'b11, 2'd3, 0, 0);
    step(1, 64'h0000_0000_0080_0000, 0, 0, 0, 0, 0, 0);
    // R6 R8: flags miss enable (only NX enabled)
    step(0, 0, 1, 1, 0, 0, 0, 5'b10110);
    // R7: flags hit enable
    step(0, 0, 1, 1, 0, 0, 0, 5'b00001);
    step(1, 64'h0, 1, 1, 0, 0, 0, 5'h1f);
    // R10: load leaving nonzero trap type blocks operations
    step(1, 64'h0000_0000_0000_8000, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 2'b01, 2'd0, 0, 0);
    step(0, 0, 1, 1, 0, 0, 0, 5'h10);
    step(1, 64'h0, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] p;
      logic [63:0] d;
      p = $urandom;
      d = {$urandom, $urandom};
      if (p[3:0] == 0) begin
        if (p[4]) d[16:14] = 3'd0;
        step(1, d, p[5], p[6], 0, 0, 0, 0);
      end else if (m_fsr[16:14] != 0 && p[7]) begin
        d[16:14] = 3'd0;
        step(1, d, 0, 0, 0, 0, 0, 0);
      end else begin
        step(0, 0, p[8] | p[9], p[10], p[12:11], p[14:13], p[15] & p[16], p[21:17] & p[26:22]);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule